// File: doc/BRIEF.md
# Tear-free counter readout

This block keeps a free-running event counter and lets a processor read it over an 8-bit register bus without ever assembling a value from bytes sampled at different times. Reading the lowest byte of the live count takes a snapshot: the whole count is copied into a small holding queue. A hardware capture strobe does the same. The processor then reads the oldest snapshot from a separate output register. It can read it as four byte lanes that all come from the same entry, or as one 32-bit word.

The queue keeps earlier snapshots. A new capture does not replace them, so software always gets the oldest unread snapshot first. A status byte reports whether the queue is empty or full. It also reports a sticky overflow flag, which is set when a capture arrives while the queue is full. Reading the status byte clears that flag.

Top module: `tearfree_counter`

## Requirements
- R1: The count rises by one on each clock with `cnt_en` high and holds when it is low. It wraps from its all-ones value to zero.
- R2: A synchronous active-high `rst` sets the count to zero, empties the queue and clears the overflow flag.
- R3: Read data is registered. `rd_data` shows the value for an access one clock after `rd_en`. Addresses 0 to 3 hold live count bits 7:0, 15:8, 23:16 and 31:24. Addresses 4 to 7 hold the same byte lanes of the oldest queued snapshot. Address 8 is the status byte. Any other address reads 0.
- R4: A byte read of address 0 pushes the count into the queue. The pushed value is the count before any increment in that same cycle.
- R5: A high `cap_strobe` also pushes the count. When it coincides with a read of address 0, exactly one entry is pushed.
- R6: The queue holds `DEPTH` entries (4 by default) and returns them oldest first. A capture never discards entries that are already held.
- R7: Byte reads of addresses 4, 5 and 6 leave the queue unchanged. A read of address 7 pops the entry. So all four lanes of one snapshot come from the same capture.
- R8: An access with `rd_en` and `rd_wide` both high returns the whole oldest snapshot on `rd_word` one clock later and pops it. During such an access `rd_data` reads 0.
- R9: The status byte has bit 0 = empty, bit 1 = full and bit 2 = overflow; its other bits are 0. A capture while the queue is full is dropped and sets overflow. Overflow stays set until the status byte is read.
- R10: Reading the queue while it is empty returns 0 and changes nothing.
- R11: When `CNT_W` is below 32, count bits above `CNT_W` read as 0 in both the live and the snapshot lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | Count one event this cycle |
| cap_strobe | input | 1 | Hardware capture request |
| rd_en | input | 1 | Read strobe, one cycle per access |
| rd_wide | input | 1 | With rd_en: 32-bit access to the snapshot queue |
| rd_addr | input | 4 | Byte register address |
| rd_data | output | 8 | Registered byte read data |
| rd_word | output | 32 | Registered 32-bit snapshot from a wide access |

## Verification
The bench builds two copies that share all inputs. One uses the default `CNT_W=32, DEPTH=4`. It covers tearing across byte lanes while the counter keeps moving, queue ordering, the full and overflow cases, and empty-queue reads. The second copy uses `CNT_W=8`. With it, the wrap from all-ones to zero is reached within a few hundred cycles, and the zeroed upper lanes can be checked. A 32-bit wrap would need billions of cycles.

// File: rtl/tearfree_counter.sv
module tearfree_counter #(
  parameter int CNT_W = 32,
  parameter int DEPTH = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cnt_en,
  input  logic        cap_strobe,
  input  logic        rd_en,
  input  logic        rd_wide,
  input  logic [3:0]  rd_addr,
  output logic [7:0]  rd_data,
  output logic [31:0] rd_word
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LW = $clog2(DEPTH + 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] mem [DEPTH];
  logic [AW-1:0]    wp, rp;
  logic [LW-1:0]    level;
  logic             ovf;
  logic [31:0]      cnt32, head32;

  wire byte_rd  = rd_en && !rd_wide;
  wire sw_cap   = byte_rd && rd_addr == 4'd0;
  wire stat_rd  = byte_rd && rd_addr == 4'd8;
  wire push_req = sw_cap || cap_strobe;
  wire empty    = level == '0;
  wire full     = level == LW'(DEPTH);
  wire push     = push_req && !full;
  wire pop      = rd_en && !empty && (rd_wide || rd_addr == 4'd7);

  always_comb begin
    cnt32 = '0;
    cnt32[CNT_W-1:0] = cnt;
    head32 = '0;
    if (!empty) head32[CNT_W-1:0] = mem[rp];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      wp    <= '0;
      rp    <= '0;
      level <= '0;
      ovf   <= 1'b0;
    end else begin
      if (cnt_en) cnt <= cnt + 1'b1;
      if (push) begin
        mem[wp] <= cnt;
        wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      end
      if (pop) rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      level <= level + LW'(push) - LW'(pop);
      ovf   <= (ovf && !stat_rd) || (push_req && full);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
      rd_word <= '0;
    end else if (rd_en) begin
      if (rd_wide) begin
        rd_data <= '0;
        rd_word <= head32;
      end else begin
        case (rd_addr)
          4'd0, 4'd1, 4'd2, 4'd3: rd_data <= cnt32[{rd_addr[1:0], 3'b000} +: 8];
          4'd4, 4'd5, 4'd6, 4'd7: rd_data <= head32[{rd_addr[1:0], 3'b000} +: 8];
          4'd8:                   rd_data <= {5'b0, ovf, full, empty};
          default:                rd_data <= '0;
        endcase
      end
    end
  end

  assert_hold_R1: assert property (@(posedge clk) disable iff (rst)
    !cnt_en |=> $stable(cnt));
  assert_step_R1: assert property (@(posedge clk) disable iff (rst)
    cnt_en |=> cnt == $past(cnt) + 1'b1);
  assert_reset_R2: assert property (@(posedge clk)
    $past(rst) |-> (cnt == '0 && level == '0 && !ovf));
  assert_single_push_R5: assert property (@(posedge clk) disable iff (rst)
    (sw_cap && cap_strobe && !full && !pop) |=> level == $past(level) + 1'b1);
  assert_bound_R6: assert property (@(posedge clk) disable iff (rst)
    level <= LW'(DEPTH));
  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (rst)
    (push_req && full) |=> ovf);
  assert_empty_read_R10: assert property (@(posedge clk) disable iff (rst)
    (rd_en && empty && !push_req) |=> level == '0);
endmodule

// File: tb/sim_tearfree_counter.sv
module sim_tearfree_counter;
  logic clk = 0, rst = 1, cnt_en = 0, cap_strobe = 0, rd_en = 0, rd_wide = 0;
  logic [3:0] rd_addr = 0;
  logic [7:0] rd_data, rd_data1;
  logic [31:0] rd_word, rd_word1;
  logic [31:0] exp_cnt = 0;
  int nchk = 0, nfail = 0;

  always #10 clk = ~clk;

  tearfree_counter u0 (.clk, .rst, .cnt_en, .cap_strobe, .rd_en, .rd_wide, .rd_addr,
    .rd_data(rd_data), .rd_word(rd_word));
  tearfree_counter #(.CNT_W(8), .DEPTH(4)) u1 (.clk, .rst, .cnt_en, .cap_strobe, .rd_en,
    .rd_wide, .rd_addr, .rd_data(rd_data1), .rd_word(rd_word1));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    nchk++;
    if (act !== expv) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    rd_en = 1; rd_addr = a;
    @(negedge clk);
    rd_en = 0; d = rd_data;
  endtask

  task automatic rdw(output logic [31:0] w);
    rd_en = 1; rd_wide = 1;
    @(negedge clk);
    rd_en = 0; rd_wide = 0; w = rd_word;
  endtask

  task automatic count(input int n);
    cnt_en = 1;
    repeat (n) @(negedge clk);
    cnt_en = 0; exp_cnt += 32'(n);
  endtask

  task automatic strobe();
    cap_strobe = 1;
    @(negedge clk);
    cap_strobe = 0;
  endtask

  task automatic do_reset();
    rst = 1;
    repeat (2) @(negedge clk);
    rst = 0; exp_cnt = 0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    do_reset();
    rd(4'd8, d); chk("R2 status after reset", 32'(d), 32'h01);
    rd(4'd1, d); chk("R2 live byte1 after reset", 32'(d), 0);
    rd(4'd2, d); chk("R3 live byte2 after reset", 32'(d), 0);
  endtask

  task automatic t_snapshot();
    logic [7:0] d, b0, b1, b2, b3;
    logic [31:0] snap;
    count(1000);
    snap = exp_cnt;
    rd(4'd0, d); chk("R3 live byte0", 32'(d), 32'(snap[7:0]));
    count(77);
    rd(4'd4, b0);
    rd(4'd5, b1);
    rd(4'd8, d); chk("R7 lanes do not pop", 32'(d), 32'h00);
    rd(4'd6, b2);
    rd(4'd7, b3);
    chk("R7 coherent snapshot", {b3, b2, b1, b0}, snap);
    rd(4'd8, d); chk("R7 byte3 pops", 32'(d), 32'h01);
    rd(4'd2, d); chk("R3 live byte2", 32'(d), 32'(exp_cnt[23:16]));
  endtask

  task automatic t_preinc();
    logic [7:0] d;
    logic [31:0] w;
    cnt_en = 1; rd_en = 1; rd_addr = 4'd0;
    @(negedge clk);
    cnt_en = 0; rd_en = 0; exp_cnt += 1;
    rdw(w); chk("R4 pre-increment capture", w, exp_cnt - 1);
    chk("R8 wide access byte data", 32'(rd_data), 0);
    rd(4'd8, d); chk("R8 wide pops", 32'(d), 32'h01);
  endtask

  task automatic t_order();
    logic [7:0] d;
    logic [31:0] a, b, w;
    a = exp_cnt; strobe();
    count(5);
    b = exp_cnt; rd(4'd0, d);
    rdw(w); chk("R6 oldest first", w, a);
    rdw(w); chk("R5 second entry", w, b);
  endtask

  task automatic t_coincide();
    logic [7:0] d;
    logic [31:0] w;
    count(3);
    cap_strobe = 1; rd_en = 1; rd_addr = 4'd0;
    @(negedge clk);
    cap_strobe = 0; rd_en = 0;
    rd(4'd8, d); chk("R5 one entry", 32'(d), 32'h00);
    rdw(w); chk("R5 coincident value", w, exp_cnt);
    rd(4'd8, d); chk("R5 only one pushed", 32'(d), 32'h01);
  endtask

  task automatic t_overflow();
    logic [7:0] d;
    logic [31:0] v [4];
    logic [31:0] w;
    for (int i = 0; i < 4; i++) begin
      v[i] = exp_cnt; strobe(); count(1);
    end
    rd(4'd8, d); chk("R9 full flag", 32'(d), 32'h02);
    strobe();
    rd(4'd8, d); chk("R9 overflow set", 32'(d), 32'h06);
    rd(4'd8, d); chk("R9 overflow cleared on read", 32'(d), 32'h02);
    for (int i = 0; i < 4; i++) begin
      rdw(w); chk("R6 drain order", w, v[i]);
    end
    rd(4'd8, d); chk("R9 empty after drain", 32'(d), 32'h01);
  endtask

  task automatic t_empty();
    logic [7:0] d;
    logic [31:0] w;
    rd(4'd5, d); chk("R10 empty lane read", 32'(d), 0);
    rd(4'd7, d); chk("R10 empty byte3 read", 32'(d), 0);
    rdw(w); chk("R10 empty wide read", w, 0);
    rd(4'd8, d); chk("R10 still empty", 32'(d), 32'h01);
    rd(4'd12, d); chk("R3 unused address", 32'(d), 0);
  endtask

  task automatic t_wrap();
    logic [7:0] d;
    logic [31:0] w;
    count(300);
    rd(4'd0, d); chk("R1 wrap narrow byte0", 32'(rd_data1), 32'(exp_cnt[7:0]));
    chk("R1 wide byte0", 32'(d), 32'(exp_cnt[7:0]));
    rd(4'd1, d); chk("R11 narrow upper lane", 32'(rd_data1), 0);
    rd(4'd5, d); chk("R11 narrow snapshot lane", 32'(rd_data1), 0);
    rdw(w); chk("R11 narrow wide word", rd_word1, 32'(exp_cnt[7:0]));
    repeat (3) @(negedge clk);
    rd(4'd1, d); chk("R1 hold without enable", 32'(d), 32'(exp_cnt[15:8]));
  endtask

  task automatic t_reset_mid();
    logic [7:0] d;
    count(9); strobe(); strobe();
    do_reset();
    rd(4'd8, d); chk("R2 queue emptied", 32'(d), 32'h01);
    rd(4'd1, d); chk("R2 count zeroed", 32'(d), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_snapshot();
    t_preinc();
    t_order();
    t_coincide();
    t_overflow();
    t_empty();
    t_wrap();
    t_reset_mid();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule